// File: doc/BRIEF.md
# Synchronous SYN and DLE Sequence Detector

This block watches the stream of characters that a synchronous receiver has already assembled, one byte at a time with a valid strobe. It raises two flags for the host's status word. The sync flag reports that a synchronising pattern has arrived. The escape flag reports a transparent-mode control sequence. Three programmable byte values supply the patterns: a first sync character, a second sync character and an escape character. Two mode inputs choose single or double sync and non-transparent or transparent framing. A parity-enable input disables escape detection.

In non-transparent mode the sync flag follows every sync pattern. In transparent mode it follows only the first sync pattern, which moves the block into a synchronised state. After that it sets only on an escape character followed by the first sync character.

An escape character followed by another escape character forms a literal escape pair and ends the sequence. The flags clear on host status reads, on later characters, on a reset-error pulse, and when the receiver is disabled.

Top module: `syn_dle_detect`

## Requirements
- R1: After reset, sync_flag, dle_flag and synced are all 0.
- R2: With mode_dbl=0 and mode_transp=0, every valid byte equal to syn1_val sets sync_flag on the next clock.
- R3: With mode_dbl=1 and mode_transp=0, sync_flag sets on the clock after a valid syn2_val byte whose preceding valid byte equals syn1_val. A pair separated by any other valid byte does not set it.
- R4: With mode_transp=1, the initial pattern (R2 or R3, chosen by mode_dbl) sets sync_flag. Once synced, a plain sync pattern no longer sets it. An unpaired escape byte followed by syn1_val does set it.
- R5: A stat_rd pulse clears sync_flag on the next clock unless a set condition occurs in the same cycle, in which case the set wins. Without stat_rd or a set, sync_flag holds.
- R6: With mode_transp=1 and par_en=0, dle_flag sets on the clock after a valid byte that follows an unpaired dle_val byte and equals neither syn2_val nor dle_val. Two consecutive dle_val bytes form a pair and leave no escape pending.
- R7: With par_en=1 or mode_transp=0, dle_flag never sets.
- R8: dle_flag clears on the clock after the next valid byte or an err_clr pulse, unless a new set occurs in that cycle.
- R9: While rx_en=0, the next clock clears sync_flag, dle_flag and synced, and forgets any partial pattern. Bytes presented while disabled have no effect.
- R10: synced rises together with the first initial-pattern detection after enable and stays 1 until rx_en falls or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low clears all state |
| mode_dbl | input | 1 | 1 = double sync pattern, 0 = single |
| mode_transp | input | 1 | 1 = transparent framing |
| par_en | input | 1 | Parity enabled; suppresses escape flag |
| syn1_val | input | W | First sync character |
| syn2_val | input | W | Second sync character |
| dle_val | input | W | Escape character |
| byte_vld | input | 1 | byte_in carries a received character |
| byte_in | input | W | Received character |
| stat_rd | input | 1 | Host status read pulse |
| err_clr | input | 1 | Reset-error command pulse |
| sync_flag | output | 1 | Sync detected flag |
| dle_flag | output | 1 | Escape sequence flag |
| synced | output | 1 | Synchronised state reached |

## Verification
The assertions assume that the three pattern values are distinct and that the mode and parity inputs change only while rx_en is low. The stimulus follows both rules. It sets the pattern values once and reprograms mode and parity only after a cycle with rx_en low. Random bytes are drawn mostly from the three pattern values, so that pairs, escaped pairs and broken sequences occur often.

// File: rtl/syn_dle_detect.sv
module syn_dle_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         mode_dbl,
  input  logic         mode_transp,
  input  logic         par_en,
  input  logic [W-1:0] syn1_val,
  input  logic [W-1:0] syn2_val,
  input  logic [W-1:0] dle_val,
  input  logic         byte_vld,
  input  logic [W-1:0] byte_in,
  input  logic         stat_rd,
  input  logic         err_clr,
  output logic         sync_flag,
  output logic         dle_flag,
  output logic         synced
);

  typedef enum logic [1:0] {ST_HUNT, ST_SEEN1, ST_SYNC} st_t;

  st_t  st, st_n;
  logic last1, lastd;

  wire m1 = byte_in == syn1_val;
  wire m2 = byte_in == syn2_val;
  wire md = byte_in == dle_val;

  wire init_hit = mode_dbl ? (last1 && m2) : m1;
  wire set_sync = byte_vld && ((mode_transp && st == ST_SYNC) ? (lastd && m1) : init_hit);
  wire set_dle  = byte_vld && mode_transp && !par_en && lastd && !m2 && !md;

  always_comb begin
    st_n = st;
    if (byte_vld && st != ST_SYNC) begin
      if (init_hit)          st_n = ST_SYNC;
      else if (mode_dbl && m1) st_n = ST_SEEN1;
      else                   st_n = ST_HUNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_HUNT;
      last1 <= 1'b0;
      lastd <= 1'b0;
      sync_flag <= 1'b0;
      dle_flag <= 1'b0;
    end else if (!rx_en) begin
      st <= ST_HUNT;
      last1 <= 1'b0;
      lastd <= 1'b0;
      sync_flag <= 1'b0;
      dle_flag <= 1'b0;
    end else begin
      st <= st_n;
      if (byte_vld) begin
        last1 <= m1;
        lastd <= md && !lastd;
      end
      if (set_sync)     sync_flag <= 1'b1;
      else if (stat_rd) sync_flag <= 1'b0;
      if (set_dle)                   dle_flag <= 1'b1;
      else if (byte_vld || err_clr)  dle_flag <= 1'b0;
    end
  end

  assign synced = st == ST_SYNC;

endmodule

// File: rtl/syn_dle_detect_chk.sv
module syn_dle_detect_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_en,
  input logic         mode_dbl,
  input logic         mode_transp,
  input logic         par_en,
  input logic [W-1:0] syn1_val,
  input logic         byte_vld,
  input logic [W-1:0] byte_in,
  input logic         stat_rd,
  input logic         err_clr,
  input logic         sync_flag,
  input logic         dle_flag,
  input logic         synced
);

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!sync_flag && !dle_flag && !synced));

  p_single_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && byte_vld && !mode_dbl && !mode_transp && byte_in == syn1_val) |=> sync_flag);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && stat_rd && !byte_vld) |=> !sync_flag);

  p_sync_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !byte_vld && !stat_rd) |=> $stable(sync_flag));

  p_dle_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dle_flag) |-> $past(mode_transp && !par_en && byte_vld));

  p_dle_errclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && err_clr && !byte_vld) |=> !dle_flag);

  p_synced_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && synced) |=> synced);

endmodule

bind syn_dle_detect syn_dle_detect_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode_dbl(mode_dbl),
  .mode_transp(mode_transp), .par_en(par_en), .syn1_val(syn1_val),
  .byte_vld(byte_vld), .byte_in(byte_in), .stat_rd(stat_rd),
  .err_clr(err_clr), .sync_flag(sync_flag), .dle_flag(dle_flag),
  .synced(synced)
);

// File: tb/syn_dle_detect_tb.sv
module syn_dle_detect_tb_top;
  localparam logic [7:0] S1 = 8'h16, S2 = 8'h26, DL = 8'h10;

  logic clk = 0, rst_n = 0;
  logic rx_en = 0, mode_dbl = 0, mode_transp = 0, par_en = 0;
  logic byte_vld = 0, stat_rd = 0, err_clr = 0;
  logic [7:0] byte_in = 0;
  logic sync_flag, dle_flag, synced;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit m_sync = 0, m_dle = 0, m_synced = 0;
  byte unsigned hist[$];

  always #10 clk = ~clk;

  syn_dle_detect #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode_dbl(mode_dbl),
    .mode_transp(mode_transp), .par_en(par_en), .syn1_val(S1),
    .syn2_val(S2), .dle_val(DL), .byte_vld(byte_vld), .byte_in(byte_in),
    .stat_rd(stat_rd), .err_clr(err_clr), .sync_flag(sync_flag),
    .dle_flag(dle_flag), .synced(synced)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      summary();
    end
  end

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit odd_dle_tail();
    int n = 0;
    for (int i = hist.size() - 1; i >= 0 && hist[i] == DL; i--) n++;
    return n % 2 == 1;
  endfunction

  task automatic model_step();
    bit ns = m_sync, nd = m_dle, ny = m_synced;
    if (!rx_en) begin
      hist.delete(); m_sync = 0; m_dle = 0; m_synced = 0;
      return;
    end
    if (stat_rd) ns = 0;
    if (byte_vld || err_clr) nd = 0;
    if (byte_vld) begin
      bit odd = odd_dle_tail();
      bit prev1 = hist.size() > 0 && hist[hist.size()-1] == S1;
      bit initial_pat = mode_dbl ? (prev1 && byte_in == S2) : (byte_in == S1);
      bit ss = (mode_transp && m_synced) ? (odd && byte_in == S1) : initial_pat;
      bit sd = mode_transp && !par_en && odd && byte_in != S2 && byte_in != DL;
      if (initial_pat) ny = 1;
      hist.push_back(byte_in);
      if (hist.size() > 200) void'(hist.pop_front());
      if (ss) ns = 1;
      if (sd) nd = 1;
    end
    m_sync = ns; m_dle = nd; m_synced = ny;
  endtask

  task automatic cyc(bit en, bit v, logic [7:0] b, bit rd, bit ec);
    string rs;
    @(negedge clk);
    rs = mode_transp ? "R4" : (mode_dbl ? "R3" : "R2");
    chk(rs, sync_flag, m_sync);
    chk("R6", dle_flag, m_dle);
    chk("R10", synced, m_synced);
    rx_en = en; byte_vld = v; byte_in = b; stat_rd = rd; err_clr = ec;
    model_step();
  endtask

  task automatic setmode(bit d, bit t, bit p);
    cyc(0, 0, 0, 0, 0);
    mode_dbl = d; mode_transp = t; par_en = p;
    cyc(1, 0, 0, 0, 0);
  endtask

  task automatic feed(logic [7:0] b);
    cyc(1, 1, b, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", sync_flag, 0); chk("R1", dle_flag, 0); chk("R1", synced, 0);
    rst_n = 1;

    // R2 single non-transparent
    setmode(0, 0, 0);
    feed(8'h55); feed(S1); cyc(1, 0, 0, 0, 0);
    chk("R2", sync_flag, 1);
    // R5 read clears, then set beats read
    cyc(1, 0, 0, 1, 0); cyc(1, 0, 0, 0, 0);
    chk("R5", sync_flag, 0);
    cyc(1, 1, S1, 1, 0); cyc(1, 0, 0, 0, 0);
    chk("R5", sync_flag, 1);

    // R3 double: broken pair, then good pair
    setmode(1, 0, 0);
    feed(S1); feed(8'h33); feed(S2); cyc(1, 0, 0, 0, 0);
    chk("R3", sync_flag, 0);
    feed(S1); feed(S2); cyc(1, 0, 0, 0, 0);
    chk("R3", sync_flag, 1); chk("R10", synced, 1);

    // R4 transparent single
    setmode(0, 1, 0);
    feed(S1); cyc(1, 0, 0, 1, 0);
    chk("R4", synced, 1);
    cyc(1, 0, 0, 0, 0); chk("R4", sync_flag, 0);
    feed(S1); cyc(1, 0, 0, 0, 0); chk("R4", sync_flag, 0);
    feed(DL); feed(S1); cyc(1, 0, 0, 0, 0); chk("R4", sync_flag, 1);
    // R6 escape sequence, R8 cleared by next byte
    feed(DL); feed(8'h41); cyc(1, 0, 0, 0, 0); chk("R6", dle_flag, 1);
    feed(8'h42); cyc(1, 0, 0, 0, 0); chk("R8", dle_flag, 0);
    feed(DL); feed(DL); feed(8'h43); cyc(1, 0, 0, 0, 0); chk("R6", dle_flag, 0);
    feed(DL); feed(S2); cyc(1, 0, 0, 0, 0); chk("R6", dle_flag, 0);
    feed(DL); feed(8'h44); cyc(1, 0, 0, 0, 1); cyc(1, 0, 0, 0, 0);
    chk("R8", dle_flag, 0);

    // R7 parity on
    setmode(0, 1, 1);
    feed(DL); feed(8'h45); cyc(1, 0, 0, 0, 0); chk("R7", dle_flag, 0);

    // R9 disable clears and ignores bytes
    setmode(0, 0, 0);
    feed(S1); cyc(0, 1, S1, 0, 0); cyc(0, 1, S1, 0, 0); cyc(0, 0, 0, 0, 0);
    chk("R9", sync_flag, 0); chk("R9", synced, 0);

    // random phase over all modes
    for (int m = 0; m < 8; m++) begin
      setmode(m[0], m[1], m[2]);
      for (int i = 0; i < 400; i++) begin
        int r = $urandom_range(0, 9);
        logic [7:0] b = (r < 3) ? S1 : (r < 5) ? S2 : (r < 8) ? DL : 8'($urandom);
        cyc(1, $urandom_range(0, 3) != 0, b,
            $urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0);
      end
    end
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    summary();
  end
endmodule